// File: doc/BRIEF.md
# I2C Target Controller with Clock-Stretch Request Flags

This block answers on an I2C bus as a target that has a 7-bit address. Software reaches it through a small word-addressed register port. The block decodes START and STOP conditions, shifts address and data bytes, and acknowledges its own address. It holds SCL low whenever the bus cannot continue without software. That happens in two cases: a received byte is waiting to be read, or the master wants to read and no byte has been supplied yet.

One word offset behaves differently for reads and writes. A read there returns three raw request flags. A write there sets the enable bit. A third flag marks the first data byte that follows an address match, so software can tell a register index from the data that comes after it. Software works the block by polling the flags. It reads the data word to take a received byte and writes the data word to supply a byte for the master. Either access lets SCL go.

Top module: `i2c_tgt`

## Requirements
- R1: After reset the status word reads 0, the data word reads 0, and neither `scl_oe_o` nor `sda_oe_o` is asserted.
- R2: Register word offsets are as follows. Offset 0x0 is data: a read returns the last received byte in bits 7:0, and a write supplies the byte to transmit. Offset 0x4 behaves by access type. A read returns status, with bit 0 the receive request, bit 1 the transmit request, bit 2 the first-byte flag, and bits 31:3 zero. A write sets control, where bit 0 enables the target. Offset 0x8 holds the own address in bits 6:0.
- R3: A START followed by the own address with R/W=0 gets an ACK in the 9th clock. Each following data byte is also ACKed. It then sets the receive request, makes the byte readable at offset 0x0, and holds SCL low until software reads the data word.
- R4: The first-byte flag is 1 for the first data byte after an address match. It is 0 for the later bytes of that transfer.
- R5: A read of offset 0x0 clears the receive request and the first-byte flag. `scl_oe_o` is deasserted on the first clock after that read.
- R6: An address that differs from the own address gets no ACK. It sets no flag and causes no stretch. The bytes that follow are ignored until the next START.
- R7: The own address with R/W=1 sets the transmit request and holds SCL low until software writes offset 0x0. The written byte is then sent MSB first, and the first-byte flag stays 0 throughout transmit.
- R8: In transmit, an ACK from the master raises the transmit request again for the next byte. A NACK ends the transfer: the request stays 0, SCL is not stretched, and SDA is released.
- R9: While the enable bit is 0, the block drives neither SCL nor SDA, raises no flag, and ACKs no address.
- R10: A repeated START restarts address matching, so the first data byte after the new match has the first-byte flag set again.
- R11: A write to offset 0x0 while the transmit request is 0 has no effect. A read of offset 0x0 while the receive request is 0 leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low (ACK or data 0) |
| reg_addr_i | input | 4 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |

## Verification
A bad bit counter or a wrong state shows up at the bus itself. The ACK moves to the wrong clock and the master sees a NACK, or transmitted bits come out shifted, within a single byte. A request flag that is stuck or lost shows within one byte time. Either SCL stays held and the bench master stalls, or SCL is released with no flag set in the status word. First-byte tracking that fails to reset is seen in the status read at the first byte after a repeated START.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W   = 8;
  localparam int CNT_W    = $clog2(BYTE_W + 1);
  localparam int OFS_DATA = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_OWN  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX_WAIT, ST_TX, ST_TX_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s      = scl_p[STAGES-1];
  assign sda_o      = sda_p[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // SDA edges while SCL stays high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [BYTE_W-2:0] own_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              tx_load_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              rx_set_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_first_o,
  output logic              tx_set_o,
  output logic              tx_clr_o,
  output logic              sda_oe_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  tgt_state_e        state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              rw_q, ack_q, first_q, ack_drv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      cnt     <= '0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      first_q <= 1'b0;
      ack_drv <= 1'b0;
    end else if (!en_i) begin
      state   <= ST_IDLE;
      ack_drv <= 1'b0;
      first_q <= 1'b0;
    end else if (start_i) begin
      state   <= ST_ADDR;
      cnt     <= '0;
      ack_drv <= 1'b0;
      first_q <= 1'b0;
    end else if (stop_i) begin
      state   <= ST_IDLE;
      ack_drv <= 1'b0;
      first_q <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise_i) begin
            shreg <= {shreg[BYTE_W-2:0], sda_i};
            cnt   <= cnt + CNT_W'(1);
          end else if (scl_fall_i && cnt == FULL) begin
            if (shreg[BYTE_W-1:1] == own_i) begin
              ack_drv <= 1'b1;
              rw_q    <= shreg[0];
              state   <= ST_ADDR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            ack_drv <= 1'b0;
            cnt     <= '0;
            if (rw_q) begin
              state <= ST_TX_WAIT;
            end else begin
              state   <= ST_RX;
              first_q <= 1'b1;
            end
          end
        end
        ST_RX: begin
          if (scl_rise_i) begin
            shreg <= {shreg[BYTE_W-2:0], sda_i};
            cnt   <= cnt + CNT_W'(1);
          end else if (scl_fall_i && cnt == FULL) begin
            ack_drv <= 1'b1;
            state   <= ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall_i) begin
            ack_drv <= 1'b0;
            cnt     <= '0;
            first_q <= 1'b0;
            state   <= ST_RX;
          end
        end
        ST_TX_WAIT: begin
          if (tx_load_i) begin
            shreg <= tx_byte_i;
            cnt   <= '0;
            state <= ST_TX;
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            shreg <= {shreg[BYTE_W-2:0], 1'b0};
            cnt   <= cnt + CNT_W'(1);
            if (cnt == FULL - CNT_W'(1)) state <= ST_TX_ACK;
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) ack_q <= ~sda_i;
          else if (scl_fall_i) state <= ack_q ? ST_TX_WAIT : ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign rx_byte_o  = shreg;
  assign rx_first_o = first_q;
  assign rx_set_o   = en_i & scl_fall_i & (state == ST_RX_ACK);
  assign tx_set_o   = en_i & scl_fall_i &
                      (((state == ST_ADDR_ACK) & rw_q) | ((state == ST_TX_ACK) & ack_q));
  assign tx_clr_o   = en_i & (start_i | stop_i);
  assign sda_oe_o   = en_i & (ack_drv | ((state == ST_TX) & ~shreg[BYTE_W-1]));
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              rx_set_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rx_first_i,
  input  logic              tx_set_i,
  input  logic              tx_clr_i,
  output logic              en_o,
  output logic [BYTE_W-2:0] own_o,
  output logic              rreq_o,
  output logic              treq_o,
  output logic              fbr_o,
  output logic              tx_load_o,
  output logic [BYTE_W-1:0] tx_byte_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic sel_data, sel_stat, sel_own, rd_clr;
  logic [BYTE_W-1:0] rx_q;
  logic unused_bits;

  assign word     = reg_addr_i[ADDR_W-1:2];
  assign sel_data = (word == WORD_W'(OFS_DATA));
  assign sel_stat = (word == WORD_W'(OFS_STAT));
  assign sel_own  = (word == WORD_W'(OFS_OWN));
  assign rd_clr   = reg_re_i & sel_data;
  assign tx_load_o = reg_we_i & sel_data & treq_o;
  assign tx_byte_o = reg_wdata_i[BYTE_W-1:0];
  assign unused_bits = ^{reg_addr_i[1:0], reg_wdata_i[REG_W-1:BYTE_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      own_o  <= '0;
      rx_q   <= '0;
      rreq_o <= 1'b0;
      treq_o <= 1'b0;
      fbr_o  <= 1'b0;
    end else begin
      if (reg_we_i && sel_stat) en_o  <= reg_wdata_i[0];
      if (reg_we_i && sel_own)  own_o <= reg_wdata_i[BYTE_W-2:0];
      if (!en_o) begin
        rreq_o <= 1'b0;
        treq_o <= 1'b0;
        fbr_o  <= 1'b0;
      end else begin
        if (rx_set_i) begin
          rx_q   <= rx_byte_i;
          rreq_o <= 1'b1;
          fbr_o  <= rx_first_i;
        end else if (rd_clr) begin
          rreq_o <= 1'b0;
          fbr_o  <= 1'b0;
        end
        if (tx_set_i) treq_o <= 1'b1;
        else if (tx_clr_i || tx_load_o) treq_o <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (sel_data)      reg_rdata_o = REG_W'(rx_q);
    else if (sel_stat) reg_rdata_o = REG_W'({fbr_o, treq_o, rreq_o});
    else if (sel_own)  reg_rdata_o = REG_W'(own_o);
  end
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o
);
  logic sda_s, scl_rise, scl_fall, start, stop;
  logic en, rreq, treq, fbr;
  logic [BYTE_W-2:0] own;
  logic rx_set, rx_first, tx_set, tx_clr, tx_load;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_tgt_fsm i_fsm (
    .clk_i, .rst_ni, .en_i(en), .own_i(own), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .tx_load_i(tx_load), .tx_byte_i(tx_byte),
    .rx_set_o(rx_set), .rx_byte_o(rx_byte), .rx_first_o(rx_first),
    .tx_set_o(tx_set), .tx_clr_o(tx_clr), .sda_oe_o
  );

  i2c_tgt_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_we_i, .reg_re_i, .reg_wdata_i, .reg_rdata_o,
    .rx_set_i(rx_set), .rx_byte_i(rx_byte), .rx_first_i(rx_first),
    .tx_set_i(tx_set), .tx_clr_i(tx_clr),
    .en_o(en), .own_o(own), .rreq_o(rreq), .treq_o(treq), .fbr_o(fbr),
    .tx_load_o(tx_load), .tx_byte_o(tx_byte)
  );

  assign scl_oe_o = en & (rreq | treq);
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_oe_o,
  input logic              sda_oe_o,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_re_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              en,
  input logic              rreq,
  input logic              treq,
  input logic              fbr
);
  a_r4_first_needs_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fbr |-> rreq);

  a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rreq && reg_re_i && reg_addr_i[ADDR_W-1:2] == '0) |=> (!rreq && !fbr));

  a_r9_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !$past(en)) |-> (!rreq && !treq && !scl_oe_o && !sda_oe_o));

  a_r2_status_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[ADDR_W-1:2] == 1) |-> (reg_rdata_o[REG_W-1:3] == '0));

  a_r7_no_first_in_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    treq |-> !fbr);
endmodule

bind i2c_tgt i2c_tgt_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_i2c_tgt.sv
module test_i2c_tgt;
  localparam int Q = 16;
  localparam logic [6:0] OWN = 7'h42;
  // bit 8: expected first-byte flag, bits 7:0: byte sent by the master
  localparam logic [8:0] RX_VEC [4] = '{9'h1A5, 9'h03C, 9'h000, 9'h0FF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic [3:0] reg_addr = '0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  i2c_tgt i_i2c_tgt (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = (a == 4'h0);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic pulse(output logic s);
    m_scl = 1'b1;
    @(negedge clk);
    while (scl_line !== 1'b1) @(negedge clk);
    wait_q();
    s = sda_line;
    m_scl = 1'b0;
    wait_q();
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; wait_q();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; wait_q();
    m_scl = 1'b1; wait_q();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b1; wait_q();
    m_sda = 1'b1; wait_q();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_q();
      pulse(s);
    end
    m_sda = 1'b1; wait_q();
    pulse(s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] b);
    logic s;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q();
      pulse(s);
      b[i] = s;
    end
    m_sda = nack; wait_q();
    pulse(s);
    m_sda = 1'b1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic ack;
    logic [7:0] b;

    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 scl_oe", 32'(scl_oe), 0);
    chk("R1 sda_oe", 32'(sda_oe), 0);
    rd(4'h4, d); chk("R1 status", d, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'h4, d); chk("R1 status after release", d, 0);
    rd(4'h0, d); chk("R1 data", d, 0);

    // R9 disabled: address ignored
    wr(4'h8, 32'(OWN));
    rd(4'h8, d); chk("R2 own address readback", d, 32'(OWN));
    bus_start();
    wbyte({OWN, 1'b0}, ack);
    chk("R9 no ack when disabled", 32'(ack), 0);
    rd(4'h4, d); chk("R9 no flags when disabled", d, 0);
    chk("R9 no stretch when disabled", 32'(scl_oe), 0);
    bus_stop();

    wr(4'h4, 32'h1);

    // R11 ignored data write while no transmit request
    wr(4'h0, 32'h77);
    rd(4'h4, d); chk("R11 write ignored status", d, 0);
    chk("R11 write ignored sda", 32'(sda_oe), 0);
    rd(4'h0, d); chk("R11 read idle data", d, 0);
    rd(4'h4, d); chk("R11 read idle status", d, 0);

    // R3 R4 R5 table-driven write transfer
    bus_start();
    wbyte({OWN, 1'b0}, ack);
    chk("R3 address ack", 32'(ack), 1);
    rd(4'h4, d); chk("R3 no flag after address", d, 0);
    for (int v = 0; v < 4; v++) begin
      wbyte(RX_VEC[v][7:0], ack);
      chk("R3 data ack", 32'(ack), 1);
      rd(4'h4, d);
      chk("R4 status first/rx", d, {29'b0, RX_VEC[v][8], 1'b0, 1'b1});
      chk("R3 stretch while pending", 32'(scl_oe), 1);
      rd(4'h0, d);
      chk("R3 data value", d, 32'(RX_VEC[v][7:0]));
      chk("R5 release one clock after read", 32'(scl_oe), 0);
      rd(4'h4, d); chk("R5 flags cleared", d, 0);
    end
    bus_stop();

    // R6 address mismatch
    bus_start();
    wbyte({OWN ^ 7'h01, 1'b0}, ack);
    chk("R6 no ack on mismatch", 32'(ack), 0);
    wbyte(8'h00, ack);
    chk("R6 following byte ignored", 32'(ack), 0);
    rd(4'h4, d); chk("R6 no flags", d, 0);
    chk("R6 no stretch", 32'(scl_oe), 0);
    bus_stop();

    // R10 repeated START restarts first-byte tracking
    bus_start();
    wbyte({OWN, 1'b0}, ack);
    wbyte(8'h11, ack);
    rd(4'h4, d); chk("R10 first byte before Sr", d, 32'h5);
    rd(4'h0, d);
    bus_rstart();
    wbyte({OWN, 1'b0}, ack);
    chk("R10 ack after Sr", 32'(ack), 1);
    wbyte(8'h22, ack);
    rd(4'h4, d); chk("R10 first byte after Sr", d, 32'h5);
    rd(4'h0, d); chk("R10 data after Sr", d, 32'h22);
    bus_stop();

    // R7 R8 transmit transfer
    bus_start();
    wbyte({OWN, 1'b1}, ack);
    chk("R7 read address ack", 32'(ack), 1);
    rd(4'h4, d); chk("R7 transmit request only", d, 32'h2);
    chk("R7 stretch before data", 32'(scl_oe), 1);
    rd(4'h0, d);
    rd(4'h4, d); chk("R11 data read leaves tx status", d, 32'h2);
    wr(4'h0, 32'hC6);
    rd(4'h4, d); chk("R7 request cleared by write", d, 0);
    chk("R7 release after write", 32'(scl_oe), 0);
    rbyte(1'b0, b);
    chk("R7 transmitted byte", 32'(b), 32'hC6);
    rd(4'h4, d); chk("R8 request after master ack", d, 32'h2);
    wr(4'h0, 32'h5A);
    rbyte(1'b1, b);
    chk("R8 second byte", 32'(b), 32'h5A);
    rd(4'h4, d); chk("R8 no request after nack", d, 0);
    chk("R8 no stretch after nack", 32'(scl_oe), 0);
    chk("R8 sda released after nack", 32'(sda_oe), 0);
    bus_stop();

    done = 1'b1;
    finish_run();
  end
endmodule